// File: doc/BRIEF.md
# Pattern-Triggered Sample Capture Controller

This block records a parallel group of digital channels into an on-chip dual-port buffer, one word per sample tick, and stops itself once a trigger pattern has been seen and the buffer has been filled to its last address. Each stored word holds one bit per channel plus a marker bit. The marker bit is set only on the word taken when the trigger pattern first matched. Until that match, the write pointer runs round the buffer and overwrites the oldest samples. After the match, it runs on to the top address and halts.

The trigger is a level pattern. A value word gives the wanted level of each channel, and a care mask picks which channels take part. A host arms the block, waits for `done`, then walks a read index through the buffer on the second port. The data comes back one cycle after the index. A pretrigger select chooses the window the host sees. With the select set, the window is the whole buffer, oldest sample first. With it clear, the window is only the trigger sample and the samples after it. Capture always ends at the top address, so the slot just past the final write is address 0. The oldest retained sample therefore sits at address 0 whether or not the pointer wrapped before the trigger.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `trig_seen` and `wrapped` are 0.
- R2: Each stored word is the channel bits plus a marker bit (returned on `rd_mark`). The marker is 1 only on the sample that first matched after arming, and 0 on every other sample.
- R3: A sample matches when every channel whose `pat_care` bit is 1 equals the corresponding `pat_value` bit. Channels with a care bit of 0 are ignored, so an all-zero care mask matches the first sample.
- R4: While `busy`, the write address advances by one on each cycle with `sample_en` high. Cycles with `sample_en` low write nothing and do not move it.
- R5: Before the trigger, a write at address DEPTH-1 is followed by a write at address 0, and `wrapped` goes to 1.
- R6: `trig_addr` takes the write address of the first matching sample. Later matches do not change it.
- R7: After the trigger, writing continues through address DEPTH-1 inclusive. On that write `busy` falls and `done` rises. A trigger on address DEPTH-1 itself ends capture at once.
- R8: A one-cycle `arm` pulse clears `done`, `trig_seen` and `wrapped`, and restarts capture at address 0, also in mid-capture. Samples while not busy are ignored and cannot set `trig_seen`.
- R9: With `pretrig_sel`=1 and `done`=1, read index i returns buffer address i and is valid for every i in 0..DEPTH-1.
- R10: With `pretrig_sel`=0 and `done`=1, read index i returns buffer address (`trig_addr`+i) mod DEPTH and is valid only for i < DEPTH-`trig_addr`. Index 0 is thus the marked sample.
- R11: `rd_data`, `rd_mark` and `rd_index_valid` are registered one cycle after `rd_index`. `rd_index_valid` is 0 while `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both capture and readout |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse to clear the flags and start capture at address 0 |
| sample_en | input | 1 | Sample tick; one word is written per high cycle while busy |
| chan_in | input | CH_W | Channel levels being sampled |
| pat_value | input | CH_W | Wanted level per channel |
| pat_care | input | CH_W | 1 = channel takes part in the match |
| pretrig_sel | input | 1 | 1 = window is the whole buffer, 0 = trigger onward |
| rd_index | input | AW | Position within the readout window |
| rd_data | output | CH_W | Channel bits of the selected word |
| rd_mark | output | 1 | Marker bit of the selected word |
| rd_index_valid | output | 1 | Index lies inside the chosen window of a finished capture |
| busy | output | 1 | Capture in progress |
| trig_seen | output | 1 | Trigger matched since arming |
| trig_addr | output | AW | Buffer address of the trigger sample |
| wrapped | output | 1 | Write pointer wrapped before the trigger |
| done | output | 1 | Capture finished |

## Verification
The match is tried with a partial care mask, where only the upper channels count. In that run a second later match must leave the trigger address alone. It is also tried with a full mask on an exact value that lands on the top address, and with an empty mask that fires on the very first sample. The three runs give trigger addresses of 5, 15 and 0, and each pins a different edge of both readout windows. A run that only matches after more than one lap separates the wrap path from the straight run. An arm in mid-capture, sample ticks before arming and ticks after done show that the restart works and that the stray ticks change nothing.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/cap_pattern_match.sv
module cap_pattern_match #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0] levels,
  input  logic [CH_W-1:0] want,
  input  logic [CH_W-1:0] care,
  output logic            hit
);
  // only channels with a care bit may break the match
  function automatic logic masked_equal(input logic [CH_W-1:0] a,
                                        input logic [CH_W-1:0] b,
                                        input logic [CH_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  assign hit = masked_equal(levels, want, care);
endmodule

// File: rtl/cap_write_seq.sv
module cap_write_seq
  import cap_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          sample_en,
  input  logic          hit,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          mark,
  output logic          busy,
  output logic          trig_seen,
  output logic [AW-1:0] trig_addr,
  output logic          wrapped,
  output logic          done
);
  localparam logic [AW-1:0] TOP = '1;

  cap_state_e state;
  logic at_top;
  logic first_hit;
  logic finish_now;

  assign busy       = (state == CAP_RUN);
  assign we         = busy && sample_en;
  assign at_top     = (waddr == TOP);
  assign first_hit  = we && hit && !trig_seen;
  assign mark       = first_hit;
  assign finish_now = we && at_top && (trig_seen || first_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CAP_IDLE;
      waddr     <= '0;
      trig_seen <= 1'b0;
      trig_addr <= '0;
      wrapped   <= 1'b0;
      done      <= 1'b0;
    end else if (arm) begin
      state     <= CAP_RUN;
      waddr     <= '0;
      trig_seen <= 1'b0;
      trig_addr <= '0;
      wrapped   <= 1'b0;
      done      <= 1'b0;
    end else if (we) begin
      if (first_hit) begin
        trig_seen <= 1'b1;
        trig_addr <= waddr;
      end
      if (finish_now) begin
        state <= CAP_IDLE;
        done  <= 1'b1;
      end else if (at_top) begin
        wrapped <= 1'b1;
        waddr   <= '0;
      end else begin
        waddr <= waddr + 1'b1;
      end
    end
  end

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !at_top && !arm) |=> (waddr == AW'($past(waddr) + 1'b1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !arm) |=> $stable(waddr));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (we && at_top && !trig_seen && !hit && !arm) |=> (waddr == '0 && wrapped && busy));

  a_r6_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen && !arm) |=> ($stable(trig_addr) && trig_seen));

  a_r2_mark_sets_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !arm) |=> (trig_seen && trig_addr == $past(waddr)));

  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (we && at_top && (trig_seen || hit) && !arm) |=> (done && !busy));

  a_r7_done_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trig_seen && !busy));

  a_r8_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (busy && waddr == '0 && !done && !trig_seen && !wrapped));
endmodule

// File: rtl/cap_dpram.sv
module cap_dpram #(
  parameter int W  = 9,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_read_window.sv
module cap_read_window #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          pretrig_sel,
  input  logic [AW-1:0] trig_addr,
  input  logic [AW-1:0] rd_index,
  output logic [AW-1:0] raddr,
  output logic          idx_valid
);
  localparam int            DEPTH = 1 << AW;
  localparam logic [AW:0]   FULL  = (AW+1)'(DEPTH);

  // first buffer address of the window; capture ends at the top,
  // so the oldest retained word is always at address 0
  function automatic logic [AW-1:0] win_base(input logic pre, input logic [AW-1:0] ta);
    return pre ? '0 : ta;
  endfunction

  // number of readable words in the window
  function automatic logic [AW:0] win_len(input logic pre, input logic [AW-1:0] ta);
    return pre ? FULL : FULL - {1'b0, ta};
  endfunction

  logic in_window;

  assign raddr     = win_base(pretrig_sel, trig_addr) + rd_index;
  assign in_window = ({1'b0, rd_index} < win_len(pretrig_sel, trig_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_valid <= 1'b0;
    else        idx_valid <= done && in_window;
  end

  a_r11_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> $past(done));

  a_r10_window_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pretrig_sel && (rd_index == ~trig_addr + 1'b1) && trig_addr != '0) |=> !idx_valid);
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl #(
  parameter int CH_W  = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            sample_en,
  input  logic [CH_W-1:0] chan_in,
  input  logic [CH_W-1:0] pat_value,
  input  logic [CH_W-1:0] pat_care,
  input  logic            pretrig_sel,
  input  logic [AW-1:0]   rd_index,
  output logic [CH_W-1:0] rd_data,
  output logic            rd_mark,
  output logic            rd_index_valid,
  output logic            busy,
  output logic            trig_seen,
  output logic [AW-1:0]   trig_addr,
  output logic            wrapped,
  output logic            done
);
  localparam int WORD_W = CH_W + 1;

  logic              pat_hit;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic              wr_mark;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;

  cap_pattern_match #(.CH_W(CH_W)) u_match (
    .levels (chan_in),
    .want   (pat_value),
    .care   (pat_care),
    .hit    (pat_hit)
  );

  cap_write_seq #(.AW(AW)) u_wseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .sample_en (sample_en),
    .hit       (pat_hit),
    .we        (wr_en),
    .waddr     (wr_addr),
    .mark      (wr_mark),
    .busy      (busy),
    .trig_seen (trig_seen),
    .trig_addr (trig_addr),
    .wrapped   (wrapped),
    .done      (done)
  );

  cap_dpram #(.W(WORD_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({wr_mark, chan_in}),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  cap_read_window #(.AW(AW)) u_rwin (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .pretrig_sel (pretrig_sel),
    .trig_addr   (trig_addr),
    .rd_index    (rd_index),
    .raddr       (rd_addr),
    .idx_valid   (rd_index_valid)
  );

  assign rd_data = rd_word[CH_W-1:0];
  assign rd_mark = rd_word[CH_W];

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !trig_seen && !wrapped) || !rst_n);
endmodule

// File: tb/sim_trig_capture_ctrl.sv
module sim_trig_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W  = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            arm;
  logic            sample_en;
  logic [CH_W-1:0] chan_in;
  logic [CH_W-1:0] pat_value;
  logic [CH_W-1:0] pat_care;
  logic            pretrig_sel;
  logic [AW-1:0]   rd_index;
  logic [CH_W-1:0] rd_data;
  logic            rd_mark;
  logic            rd_index_valid;
  logic            busy;
  logic            trig_seen;
  logic [AW-1:0]   trig_addr;
  logic            wrapped;
  logic            done;

  trig_capture_ctrl #(.CH_W(CH_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en), .chan_in(chan_in),
    .pat_value(pat_value), .pat_care(pat_care), .pretrig_sel(pretrig_sel),
    .rd_index(rd_index), .rd_data(rd_data), .rd_mark(rd_mark),
    .rd_index_valid(rd_index_valid), .busy(busy), .trig_seen(trig_seen),
    .trig_addr(trig_addr), .wrapped(wrapped), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model of the buffer, built from the requirements
  logic [CH_W:0] m_mem [DEPTH];
  logic m_busy = 1'b0, m_trig = 1'b0, m_wrap = 1'b0, m_done = 1'b0;
  int   m_addr = 0, m_taddr = 0;

  typedef struct {
    logic          v;
    logic          mk;
    logic [CH_W-1:0] d;
    logic          pre;
    int            idx;
    int            iss;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_arm();
    arm = 1'b1;
    m_busy = 1'b1; m_trig = 1'b0; m_wrap = 1'b0; m_done = 1'b0;
    m_addr = 0; m_taddr = 0;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // one sample tick; starts and ends at a falling edge
  task automatic tick(input logic [CH_W-1:0] d);
    logic first;
    chan_in = d; sample_en = 1'b1;
    if (m_busy) begin
      first = !m_trig && (((d ^ pat_value) & pat_care) == '0);
      m_mem[m_addr] = {first, d};
      if (first) begin m_trig = 1'b1; m_taddr = m_addr; end
      if (m_addr == DEPTH-1) begin
        if (m_trig) begin m_busy = 1'b0; m_done = 1'b1; end
        else begin m_wrap = 1'b1; m_addr = 0; end
      end else m_addr++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    sample_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // driver: issue one read and push the expected reply
  task automatic rd_req(input int idx);
    exp_t e;
    int phys;
    rd_index = AW'(idx);
    phys   = pretrig_sel ? idx : (m_taddr + idx) % DEPTH;
    e.v    = m_done && (pretrig_sel || idx < DEPTH - m_taddr);
    e.mk   = m_mem[phys][CH_W];
    e.d    = m_mem[phys][CH_W-1:0];
    e.pre  = pretrig_sel;
    e.idx  = idx;
    e.iss  = cyc;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic read_all(input logic pre);
    pretrig_sel = pre;
    for (int i = 0; i < DEPTH; i++) rd_req(i);
    @(negedge clk);
  endtask

  // monitor: compare each reply one cycle after its request (R11)
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].iss < cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      if (e.pre) begin
        check("R9", $sformatf("valid idx %0d", e.idx), 32'(rd_index_valid), 32'(e.v));
        if (e.v) begin
          check("R9", $sformatf("data idx %0d", e.idx), 32'(rd_data), 32'(e.d));
          check("R2", $sformatf("mark idx %0d", e.idx), 32'(rd_mark), 32'(e.mk));
        end
      end else begin
        check("R10", $sformatf("valid idx %0d", e.idx), 32'(rd_index_valid), 32'(e.v));
        if (e.v) begin
          check("R10", $sformatf("data idx %0d", e.idx), 32'(rd_data), 32'(e.d));
          check("R2", $sformatf("mark idx %0d", e.idx), 32'(rd_mark), 32'(e.mk));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; sample_en = 1'b0; chan_in = '0;
    pat_value = '0; pat_care = '0; pretrig_sel = 1'b0; rd_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "busy",      32'(busy), 0);
    check("R1", "done",      32'(done), 0);
    check("R1", "trig_seen", 32'(trig_seen), 0);
    check("R1", "wrapped",   32'(wrapped), 0);

    // R8: ticks before arming are ignored, even with an always-match mask
    pat_care = '0;
    for (int k = 0; k < 4; k++) tick(8'(k));
    idle(1);
    check("R8", "trig_seen before arm", 32'(trig_seen), 0);
    check("R8", "busy before arm",      32'(busy), 0);

    // scenario A: partial mask, second match later, gaps in the tick stream
    pat_value = 8'hA0; pat_care = 8'hF0;
    do_arm();
    check("R8", "busy after arm", 32'(busy), 1);
    pretrig_sel = 1'b1;
    rd_req(0); rd_req(1);            // R11: nothing valid before done
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++) begin
      if (k == 3) idle(2);           // R4: low ticks do not move the pointer
      if (k == DEPTH-1) begin
        check("R7", "busy before last write", 32'(busy), 1);
        check("R7", "done before last write", 32'(done), 0);
      end
      tick((k == 5 || k == 7) ? {4'hA, 4'(k)} : {4'h3, 4'(k)});
    end
    idle(1);
    check("R7", "done at top", 32'(done), 1);
    check("R7", "busy at top", 32'(busy), 0);
    check("R6", "trig_addr first match", 32'(trig_addr), 5);
    check("R4", "no wrap with gaps", 32'(wrapped), 0);
    read_all(1'b1);
    read_all(1'b0);

    // scenario B: restart mid-capture, then trigger after a full lap
    pat_value = 8'h5A; pat_care = 8'hFF;
    do_arm();
    for (int k = 0; k < 3; k++) tick(8'h10 + 8'(k));
    idle(1);
    do_arm();
    check("R8", "flags cleared by re-arm", 32'({done, trig_seen, wrapped}), 0);
    for (int k = 0; k < 20; k++) begin
      tick(8'h20 + 8'(k));
      if (k == DEPTH-2) check("R5", "wrapped before top", 32'(wrapped), 0);
    end
    check("R5", "wrapped after lap", 32'(wrapped), 1);
    tick(8'h5A);
    check("R3", "exact match trig_seen", 32'(trig_seen), 1);
    while (m_busy) tick(8'h40 + 8'(m_addr));
    idle(1);
    check("R5", "trig_addr after wrap", 32'(trig_addr), 4);
    check("R7", "done after wrap run", 32'(done), 1);
    // ticks after done change nothing
    for (int k = 0; k < 3; k++) tick(8'h5A);
    idle(1);
    check("R8", "trig_addr after late ticks", 32'(trig_addr), 4);
    read_all(1'b1);
    read_all(1'b0);

    // scenario C: empty mask fires on the first sample
    pat_care = '0;
    do_arm();
    for (int k = 0; k < DEPTH; k++) tick(8'(k * 7));
    idle(1);
    check("R3", "empty mask trig_addr", 32'(trig_addr), 0);
    check("R7", "empty mask done", 32'(done), 1);
    read_all(1'b0);

    // scenario D: first match on the top address ends capture at once
    pat_value = 8'h5A; pat_care = 8'hFF;
    do_arm();
    for (int k = 0; k < DEPTH-1; k++) tick(8'(k));
    check("R3", "no match yet", 32'(trig_seen), 0);
    tick(8'h5A);
    idle(1);
    check("R7", "trigger on top done", 32'(done), 1);
    check("R6", "trigger on top addr", 32'(trig_addr), DEPTH-1);
    check("R5", "no wrap on top trigger", 32'(wrapped), 0);
    read_all(1'b0);
    read_all(1'b1);

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule